// File: doc/BRIEF.md
# CPU Reset Exception Sequencer

This block gathers every reset request that can reach a small processor core and turns each one into a well-defined architectural start state. It watches two active-low reset pins and a watchdog overflow pulse. The first pin requests a power-on reset and the second requests a manual reset. The watchdog pulse is qualified by the watchdog's mode bit and its reset-select bit. The block drives the exception-event code, the vector base, the status fields (privileged mode, register bank, block flag, FPU-disable flag and a 4-bit interrupt mask) and a one-cycle program-counter load strobe with its target address. It also drives a peripheral-initialise signal that sends on-chip modules back to their reset state.

Both pins pass through a two-stage synchroniser. Each pin takes effect at once and is released cleanly. A power-on request rewrites the whole start state every cycle it stays active. A manual request rewrites only the event code. Once the last request ends, the core is told to fetch from the reset vector. Releasing the power-on pin while the manual pin is still held leaves a manual reset pending, so the manual sequence follows the power-on one. Releasing both pins together gives only the power-on result.

Top module: `cpu_reset_seq`

## Requirements
- R1: A low level on `extResetN` requests a power-on reset. This takes effect asynchronously through the synchroniser. After a release, the request remains active for two more rising edges.
- R2: In every cycle a power-on reset is active, `eventCode` is loaded with 0x000 and `vecBase` is loaded with 0x0000_0000. The new values are visible from the next cycle.
- R3: A power-on reset sets `srMd`, `srRb` and `srBl` to 1, clears `srFd` to 0, and sets `srImask` to 4'b1111.
- R4: A `wdtOverflow` pulse causes a power-on reset only when `wdtModeBit` is 1 and `wdtResetSel` is 0. With any other setting of those two bits the pulse changes no output.
- R5: `pcLoad` is high for exactly one cycle. That cycle comes two cycles after the last cycle in which any reset request was active, which is one cycle after the final state write. `pcTarget` is always 0xA000_0000.
- R6: A low level on `manResetN`, with no power-on request, loads `eventCode` with 0x020. It leaves `vecBase` and the status fields unchanged, does not raise `periphInit`, and is followed by a `pcLoad` pulse.
- R7: When a power-on request and a manual request are active in the same cycle, the power-on reset wins.
- R8: With both pins low, releasing `extResetN` before `manResetN` leaves a manual reset pending, and the final `eventCode` is 0x020. Releasing both pins in the same cycle gives no manual reset, and the final `eventCode` is 0x000.
- R9: `periphInit` is high in the cycle after each cycle in which a power-on reset was active, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| extResetN | input | 1 | Power-on reset pin, active low, asynchronous |
| manResetN | input | 1 | Manual reset pin, active low, asynchronous |
| wdtOverflow | input | 1 | Watchdog overflow pulse, synchronous |
| wdtModeBit | input | 1 | Watchdog mode bit (1 = watchdog-timer mode) |
| wdtResetSel | input | 1 | Watchdog reset-select bit (0 = power-on type) |
| eventCode | output | 12 | Exception-event code register |
| vecBase | output | 32 | Vector base register |
| srMd | output | 1 | Status: privileged mode |
| srRb | output | 1 | Status: register bank select |
| srBl | output | 1 | Status: exception block flag |
| srFd | output | 1 | Status: FPU disable |
| srImask | output | 4 | Status: interrupt mask level |
| pcLoad | output | 1 | One-cycle program-counter load strobe |
| pcTarget | output | 32 | Program-counter load address |
| periphInit | output | 1 | Peripheral initialise request |

## Verification
The two pins are driven in four orders: power-on released ahead of manual, both released in one cycle, manual alone, and manual held when power-on arrives. The final event code and the number of load pulses distinguish a pending manual reset from a clean one and show which request has priority. The watchdog pulse is tried under all three non-power-on bit settings and the power-on setting. This separates a qualified overflow from an ignored one by whether `periphInit` and `pcLoad` appear. A behavioural model compares every output on every clock, so the exact pulse cycle and any stray write are caught.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  // Write requests from the control side to the state registers
  typedef struct packed {
    logic loadPor;
    logic loadMan;
  } rstStrobe_t;

  localparam int EVT_W = 12;
  localparam logic [EVT_W-1:0] EVT_CODE_POR = 12'h000;
  localparam logic [EVT_W-1:0] EVT_CODE_MAN = 12'h020;

endpackage

// File: rtl/reset_pin_sync.sv
module reset_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pinN,
  output logic syncN
);
  logic [STAGES-1:0] chain;

  // Assert at once, release after STAGES rising edges
  always_ff @(posedge clk or negedge pinN) begin
    if (!pinN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncN = chain[STAGES-1];
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
  import reset_seq_pkg::*;
(
  input  logic       clk,
  input  logic       extSyncN,
  input  logic       manSyncN,
  input  logic       wdtOverflow,
  input  logic       wdtModeBit,
  input  logic       wdtResetSel,
  output rstStrobe_t strobes,
  output logic       pcLoad,
  output logic       periphInit
);
  logic wdtPor, porReq, manReq, anyLoad, lastLoad;

  always_comb begin
    wdtPor          = wdtOverflow & wdtModeBit & ~wdtResetSel;
    porReq          = ~extSyncN | wdtPor;
    manReq          = ~manSyncN;
    strobes.loadPor = porReq;
    strobes.loadMan = manReq & ~porReq;   // power-on wins
    anyLoad         = strobes.loadPor | strobes.loadMan;
  end

  // lastLoad marks a write just made; the PC strobe follows once writes stop
  always_ff @(posedge clk) begin
    lastLoad   <= anyLoad;
    pcLoad     <= lastLoad & ~anyLoad;
    periphInit <= strobes.loadPor;
  end

  // Checker arming, so nothing looks before the first edges
  logic armA = 1'b0;
  logic armB = 1'b0;
  always_ff @(posedge clk) begin
    armA <= 1'b1;
    armB <= armA;
  end

  a_r5_pc_single: assert property (@(posedge clk) disable iff (!armB)
    pcLoad |=> !pcLoad);

  a_r5_pc_after_write: assert property (@(posedge clk) disable iff (!armB)
    pcLoad |-> ($past(anyLoad, 2) && !$past(anyLoad)));

  a_r4_wdt_ignored: assert property (@(posedge clk) disable iff (!armB)
    (wdtOverflow && !(wdtModeBit && !wdtResetSel) && extSyncN) |=> !periphInit);

  a_r7_por_priority: assert property (@(posedge clk) disable iff (!armB)
    (!extSyncN && !manSyncN) |=> periphInit);
endmodule

// File: rtl/reset_datapath.sv
module reset_datapath
  import reset_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMASK_W = 4,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = 32'hA000_0000
) (
  input  logic               clk,
  input  rstStrobe_t         strobes,
  output logic [EVT_W-1:0]   eventCode,
  output logic [ADDR_W-1:0]  vecBase,
  output logic               srMd,
  output logic               srRb,
  output logic               srBl,
  output logic               srFd,
  output logic [IMASK_W-1:0] srImask,
  output logic [ADDR_W-1:0]  pcTarget
);
  always_ff @(posedge clk) begin
    if (strobes.loadPor) begin
      eventCode <= EVT_CODE_POR;
      vecBase   <= '0;
      srMd      <= 1'b1;
      srRb      <= 1'b1;
      srBl      <= 1'b1;
      srFd      <= 1'b0;
      srImask   <= '1;
    end else if (strobes.loadMan) begin
      eventCode <= EVT_CODE_MAN;
    end
  end

  assign pcTarget = RESET_VECTOR;

  logic armA = 1'b0;
  always_ff @(posedge clk) armA <= 1'b1;

  a_r2_por_values: assert property (@(posedge clk) disable iff (!armA)
    strobes.loadPor |=> (eventCode == EVT_CODE_POR && vecBase == '0));

  a_r3_status_values: assert property (@(posedge clk) disable iff (!armA)
    strobes.loadPor |=> (srMd && srRb && srBl && !srFd && srImask == '1));

  a_r6_manual_code: assert property (@(posedge clk) disable iff (!armA)
    strobes.loadMan |=> (eventCode == EVT_CODE_MAN && $stable(vecBase) && $stable(srImask)));
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import reset_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32,
  parameter int IMASK_W     = 4,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = 32'hA000_0000
) (
  input  logic               clk,
  input  logic               extResetN,
  input  logic               manResetN,
  input  logic               wdtOverflow,
  input  logic               wdtModeBit,
  input  logic               wdtResetSel,
  output logic [EVT_W-1:0]   eventCode,
  output logic [ADDR_W-1:0]  vecBase,
  output logic               srMd,
  output logic               srRb,
  output logic               srBl,
  output logic               srFd,
  output logic [IMASK_W-1:0] srImask,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcTarget,
  output logic               periphInit
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pinsN, syncedN;
  rstStrobe_t strobes;

  assign pinsN = {manResetN, extResetN};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    reset_pin_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .pinN (pinsN[p]),
      .syncN(syncedN[p])
    );
  end

  reset_ctrl uCtrl (
    .clk        (clk),
    .extSyncN   (syncedN[0]),
    .manSyncN   (syncedN[1]),
    .wdtOverflow(wdtOverflow),
    .wdtModeBit (wdtModeBit),
    .wdtResetSel(wdtResetSel),
    .strobes    (strobes),
    .pcLoad     (pcLoad),
    .periphInit (periphInit)
  );

  reset_datapath #(
    .ADDR_W      (ADDR_W),
    .IMASK_W     (IMASK_W),
    .RESET_VECTOR(RESET_VECTOR)
  ) uDp (
    .clk      (clk),
    .strobes  (strobes),
    .eventCode(eventCode),
    .vecBase  (vecBase),
    .srMd     (srMd),
    .srRb     (srRb),
    .srBl     (srBl),
    .srFd     (srFd),
    .srImask  (srImask),
    .pcTarget (pcTarget)
  );
endmodule

// File: tb/cpu_reset_seq_test.sv
module cpu_reset_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic extResetN = 1'b1, manResetN = 1'b1;
  logic wdtOverflow = 1'b0, wdtModeBit = 1'b0, wdtResetSel = 1'b0;
  logic [11:0] eventCode;
  logic [31:0] vecBase, pcTarget;
  logic srMd, srRb, srBl, srFd, pcLoad, periphInit;
  logic [3:0] srImask;

  int nChecks = 0, nFails = 0;
  int pcCount = 0, piCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_reset_seq uut (
    .clk(clk), .extResetN(extResetN), .manResetN(manResetN),
    .wdtOverflow(wdtOverflow), .wdtModeBit(wdtModeBit), .wdtResetSel(wdtResetSel),
    .eventCode(eventCode), .vecBase(vecBase), .srMd(srMd), .srRb(srRb),
    .srBl(srBl), .srFd(srFd), .srImask(srImask), .pcLoad(pcLoad),
    .pcTarget(pcTarget), .periphInit(periphInit)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped at every rising edge
  int mExtS1 = 0, mExtS2 = 0, mManS1 = 0, mManS2 = 0;
  int mEvt = 0, mVbr = 0, mSrOk = 0, mKnown = 0;
  int mLast = 0, mPc = 0, mPi = 0;

  always @(posedge clk) begin
    int extLow, manLow, por, man, any;
    extLow = (!extResetN || mExtS2 == 0) ? 1 : 0;
    manLow = (!manResetN || mManS2 == 0) ? 1 : 0;
    por = (extLow || (wdtOverflow && wdtModeBit && !wdtResetSel)) ? 1 : 0;
    man = (manLow && !por) ? 1 : 0;
    any = (por || man) ? 1 : 0;
    if (por) begin mEvt = 'h000; mVbr = 0; mSrOk = 1; mKnown = 1; end
    else if (man) mEvt = 'h020;
    mPc = (mLast && !any) ? 1 : 0;
    mLast = any;
    mPi = por;
    if (!extResetN) begin mExtS1 = 0; mExtS2 = 0; end
    else begin mExtS2 = mExtS1; mExtS1 = 1; end
    if (!manResetN) begin mManS1 = 0; mManS2 = 0; end
    else begin mManS2 = mManS1; mManS1 = 1; end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (mKnown) begin
      chk("R2/R6 eventCode", 32'(eventCode), 32'(mEvt));
      chk("R2 vecBase", vecBase, 32'(mVbr));
      chk("R3 status", {27'd0, srMd, srRb, srBl, srFd, 1'b0} | 32'(srImask) << 8,
          mSrOk ? (32'b11100 | 32'hF00) : 32'hx);
      chk("R5 pcLoad", 32'(pcLoad), 32'(mPc));
      chk("R9 periphInit", 32'(periphInit), 32'(mPi));
      chk("R5 pcTarget", pcTarget, 32'hA000_0000);
    end
    if (pcLoad) pcCount++;
    if (periphInit) piCount++;
  end

  task automatic clearCounts();
    @(posedge clk); #1;
    pcCount = 0; piCount = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wdtPulse(logic mode, logic sel);
    @(negedge clk);
    wdtModeBit = mode; wdtResetSel = sel; wdtOverflow = 1'b1;
    @(negedge clk);
    wdtOverflow = 1'b0;
    idle(8);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    #2;
    extResetN = 1'b0; manResetN = 1'b0;
    clearCounts();
    idle(5);
    // R1: pin held low, power-on state present
    chk("R1 periphInit while held", 32'(periphInit), 32'd1);
    chk("R1 eventCode while held", 32'(eventCode), 32'h000);
    chk("R3 imask after power-on", 32'(srImask), 32'hF);

    // R8: power-on pin released first, manual pending
    extResetN = 1'b1;
    idle(3);
    manResetN = 1'b1;
    idle(8);
    chk("R8 wrong order gives manual code", 32'(eventCode), 32'h020);
    chk("R5 one pc pulse after wrong order", 32'(pcCount), 32'd1);

    // R8: both released in the same cycle
    clearCounts();
    @(negedge clk);
    extResetN = 1'b0; manResetN = 1'b0;
    idle(5);
    extResetN = 1'b1; manResetN = 1'b1;
    idle(8);
    chk("R8 same-cycle release code", 32'(eventCode), 32'h000);
    chk("R8 same-cycle one pc pulse", 32'(pcCount), 32'd1);

    // R6: manual pin alone
    clearCounts();
    @(negedge clk);
    manResetN = 1'b0;
    idle(3);
    manResetN = 1'b1;
    idle(8);
    chk("R6 manual code", 32'(eventCode), 32'h020);
    chk("R6 no periphInit on manual", 32'(piCount), 32'd0);
    chk("R6 vecBase kept", vecBase, 32'h0);
    chk("R5 pc pulse after manual", 32'(pcCount), 32'd1);

    // R4: watchdog settings that must be ignored
    clearCounts();
    wdtPulse(1'b0, 1'b0);
    wdtPulse(1'b0, 1'b1);
    wdtPulse(1'b1, 1'b1);
    chk("R4 ignored overflow keeps code", 32'(eventCode), 32'h020);
    chk("R4 ignored overflow no pc", 32'(pcCount), 32'd0);
    chk("R4 ignored overflow no periphInit", 32'(piCount), 32'd0);

    // R4: qualified overflow causes power-on
    clearCounts();
    wdtPulse(1'b1, 1'b0);
    chk("R4 qualified overflow code", 32'(eventCode), 32'h000);
    chk("R9 one periphInit cycle", 32'(piCount), 32'd1);
    chk("R5 pc pulse after watchdog", 32'(pcCount), 32'd1);

    // R7: manual held, power-on arrives on top
    @(negedge clk);
    manResetN = 1'b0;
    idle(4);
    chk("R7 manual code before overlap", 32'(eventCode), 32'h020);
    extResetN = 1'b0;
    idle(4);
    chk("R7 power-on wins code", 32'(eventCode), 32'h000);
    chk("R7 power-on wins periphInit", 32'(periphInit), 32'd1);
    extResetN = 1'b1; manResetN = 1'b1;
    idle(8);
    chk("R7 final code", 32'(eventCode), 32'h000);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule